// File: doc/BRIEF.md
# Direct-Page Bit Test, Branch and Set Unit

This unit executes the single-bit instructions that work on one byte of the first 256 bytes of memory. It handles two kinds. The first kind tests one bit and branches on that bit. The second kind forces one bit of the byte to 1. The bit number and, for the branch kind, the polarity are both taken from the opcode. The branch kind also copies the tested bit into the carry flag.

A command is offered on a valid/ready handshake. It carries the opcode, the direct address byte, the displacement byte, the address of the instruction and the current carry. The unit reads the byte through a synchronous memory port, in which read data appear one cycle after the read strobe. For the set kind it then writes the byte back. It returns the next program counter and the carry, together with a one-cycle `done` pulse in the last cycle of the instruction.

Back-pressure works as follows. `cmd_ready` is high only while the unit is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. From that edge until the cycle after `done`, `cmd_ready` stays low, and anything presented on the command pins is ignored.

Top module: `bitop_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `done` is 0, and neither `mem_rd` nor `mem_wr` is asserted until a command is accepted.
- R2: A command is accepted only when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` is low from the acceptance until the cycle after `done`. Commands presented while it is low have no effect on memory, `pc_out` or `carry_out`.
- R3: Each accepted command makes exactly one read, at address {8'h00, `cmd_dir`}. The read is issued in the cycle after acceptance. Every access has a zero upper address byte.
- R4: Opcodes 0x00–0x0F test bit `opcode[3:1]` of the byte. An even opcode branches when that bit is 1, and an odd opcode branches when it is 0.
- R5: For the branch group, `pc_out` is `cmd_pc` + 3 + the sign-extended displacement when the branch is taken, and `cmd_pc` + 3 when it is not. Both sums wrap modulo 2^16.
- R6: For the branch group, `carry_out` equals the tested bit, and no memory write is made.
- R7: Even opcodes 0x10–0x1E write, to the same address, the read byte with bit `opcode[3:1]` forced to 1 and every other bit kept. This is the only write the command makes.
- R8: For the set group, `pc_out` is `cmd_pc` + 2 and `carry_out` equals `cmd_carry`.
- R9: Counting the acceptance cycle as cycle 1, `done` is high for exactly one cycle. That cycle is cycle 5 for the branch group and cycle 4 for all other opcodes.
- R10: Any other opcode (odd 0x11–0x1F, or 0x20 and above) makes no write. It returns `pc_out` = `cmd_pc` and `carry_out` = `cmd_carry`, with the 4-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_dir | input | 8 | Direct-page address byte |
| cmd_disp | input | 8 | Signed branch displacement |
| cmd_pc | input | 16 | Address of the instruction |
| cmd_carry | input | 1 | Carry flag before the instruction |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe, data valid next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| pc_out | output | 16 | Next program counter, valid with `done` |
| carry_out | output | 1 | Carry after the instruction, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Random opcodes are drawn over the whole branch and set range, with occasional unsupported values, against random memory contents. This separates polarity mistakes from bit-index mistakes, because each bit is tested both at 0 and at 1 under both polarities. Directed cases cover the extreme displacements 0x7F and 0x80 with the program counter near both ends of the address space, which exposes a wrong sign extension or a missing wrap. They also cover setting a bit that is already 1, address 0xFF, and opcodes 0x11 and 0x20. While each command runs, a second command with a write opcode is held on the bus, and a shadow copy of all 256 bytes is compared after every instruction. Any stray or extra write therefore shows up.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EXEC, ST_HOLD, ST_DONE
  } bitop_state_e;

  typedef enum logic [1:0] {
    KIND_BRANCH, KIND_SET, KIND_NONE
  } bitop_kind_e;

  typedef struct packed {
    bitop_kind_e      kind;
    logic             on_one;
    logic [IDX_W-1:0] idx;
  } bitop_dec_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [7:0] opcode,
  output bitop_dec_t dec
);
  always_comb begin
    dec.idx    = opcode[IDX_W:1];
    dec.on_one = ~opcode[0];
    if (opcode[7:5] != 3'b000)
      dec.kind = KIND_NONE;
    else if (!opcode[4])
      dec.kind = KIND_BRANCH;
    else if (!opcode[0])
      dec.kind = KIND_SET;
    else
      dec.kind = KIND_NONE;
  end
endmodule

// File: rtl/bitop_path.sv
module bitop_path
  import bitop_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic [BYTE_W-1:0] rdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic              on_one,
  input  logic [PC_W-1:0]   pc,
  input  logic [7:0]        disp,
  output logic              bit_val,
  output logic [PC_W-1:0]   br_pc,
  output logic [PC_W-1:0]   set_pc,
  output logic [BYTE_W-1:0] wdata
);
  localparam int unsigned EXT_W = PC_W - 8;
  logic [BYTE_W-1:0] mask;
  logic              taken;
  logic [PC_W-1:0]   offs;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end

  assign bit_val = |(rdata & mask);
  assign taken   = on_one ? bit_val : ~bit_val;
  assign offs    = taken ? {{EXT_W{disp[7]}}, disp} : '0;
  assign br_pc   = pc + PC_W'(3) + offs;
  assign set_pc  = pc + PC_W'(2);
  assign wdata   = rdata | mask;
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_branch,
  output logic idle,
  output logic rd_cyc,
  output logic exec_cyc,
  output logic done
);
  bitop_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) st_nx = ST_READ;
      ST_READ: st_nx = ST_EXEC;
      ST_EXEC: st_nx = is_branch ? ST_HOLD : ST_DONE;
      ST_HOLD: st_nx = ST_DONE;
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign idle     = (st == ST_IDLE);
  assign rd_cyc   = (st == ST_READ);
  assign exec_cyc = (st == ST_EXEC);
  assign done     = (st == ST_DONE);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_opcode,
  input  logic [7:0]        cmd_dir,
  input  logic [7:0]        cmd_disp,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic              cmd_carry,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              carry_out,
  output logic              done
);
  localparam int unsigned HI_W = ADDR_W - 8;

  bitop_dec_t        dec_in, dec_q;
  logic [7:0]        dir_q, disp_q;
  logic [PC_W-1:0]   pc_q;
  logic              cin_q;
  logic              accept, idle, rd_cyc, exec_cyc;
  logic              bit_val;
  logic [PC_W-1:0]   br_pc, set_pc;
  logic [BYTE_W-1:0] wdata;
  logic [2:0]        age;

  bitop_decode u_dec (.opcode(cmd_opcode), .dec(dec_in));

  assign accept    = cmd_valid & idle;
  assign cmd_ready = idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q  <= '{kind: KIND_NONE, on_one: 1'b0, idx: '0};
      dir_q  <= '0;
      disp_q <= '0;
      pc_q   <= '0;
      cin_q  <= 1'b0;
    end else if (accept) begin
      dec_q  <= dec_in;
      dir_q  <= cmd_dir;
      disp_q <= cmd_disp;
      pc_q   <= cmd_pc;
      cin_q  <= cmd_carry;
    end
  end

  bitop_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .is_branch(dec_q.kind == KIND_BRANCH),
    .idle(idle), .rd_cyc(rd_cyc), .exec_cyc(exec_cyc), .done(done)
  );

  bitop_path #(.PC_W(PC_W)) u_path (
    .rdata(mem_rdata), .idx(dec_q.idx), .on_one(dec_q.on_one),
    .pc(pc_q), .disp(disp_q), .bit_val(bit_val),
    .br_pc(br_pc), .set_pc(set_pc), .wdata(wdata)
  );

  assign mem_addr  = {{HI_W{1'b0}}, dir_q};
  assign mem_rd    = rd_cyc;
  assign mem_wr    = exec_cyc & (dec_q.kind == KIND_SET);
  assign mem_wdata = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out    <= '0;
      carry_out <= 1'b0;
    end else if (exec_cyc) begin
      case (dec_q.kind)
        KIND_BRANCH: begin pc_out <= br_pc;  carry_out <= bit_val; end
        KIND_SET:    begin pc_out <= set_pc; carry_out <= cin_q;   end
        default:     begin pc_out <= pc_q;   carry_out <= cin_q;   end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       age <= '0;
    else if (accept)  age <= 3'd1;
    else if (!idle && age != 3'd7) age <= age + 3'd1;
  end

  // R9
  cycle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (age == ((dec_q.kind == KIND_BRANCH) ? 3'd4 : 3'd3)));
  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  // R7
  only_set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (((mem_wdata & mem_rdata) == mem_rdata) &&
                ($countones(mem_wdata ^ mem_rdata) <= 1)));
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || done) |-> !cmd_ready);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = '0, cmd_dir = '0, cmd_disp = '0;
  logic [15:0] cmd_pc = '0;
  logic        cmd_carry = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pc_out;
  logic        carry_out, done;

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned rd_cnt = 0, wr_cnt = 0;
  bit          addr_bad = 1'b0;
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];

  always #10 clk = ~clk;

  bitop_unit dut (.*);

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_cnt++;
    end
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt++;
    end
    if ((mem_rd || mem_wr) && mem_addr[15:8] != 8'h00) addr_bad = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pc(input logic [7:0] op, input logic [7:0] b,
                                         input logic [15:0] pc, input logic [7:0] d);
    logic bv;
    bv = b[op[3:1]];
    if (op < 8'h10)
      return ((op[0] == 1'b0) == (bv == 1'b1)) ? pc + 16'd3 + {{8{d[7]}}, d} : pc + 16'd3;
    else if (op < 8'h20 && !op[0])
      return pc + 16'd2;
    return pc;
  endfunction

  task automatic run(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d,
                     input logic [15:0] pc, input logic cin);
    logic [7:0]  b;
    logic [15:0] epc;
    logic        ec;
    int          ecyc, cyc, ewr;
    bit          rdy_ok, same;
    b    = shadow[a];
    epc  = exp_pc(op, b, pc, d);
    ec   = (op < 8'h10) ? b[op[3:1]] : cin;
    ecyc = (op < 8'h10) ? 5 : 4;
    ewr  = (op >= 8'h10 && op < 8'h20 && !op[0]) ? 1 : 0;
    if (ewr == 1) shadow[a] = b | (8'h01 << op[3:1]);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; addr_bad = 1'b0;
    chk(cmd_ready === 1'b1, "R2", "ready while idle", {31'd0, cmd_ready}, 1);
    cmd_valid = 1'b1; cmd_opcode = op; cmd_dir = a; cmd_disp = d;
    cmd_pc = pc; cmd_carry = cin;
    @(negedge clk);
    // R2: junk write command held on the bus while busy
    cmd_opcode = 8'h1E; cmd_dir = a ^ 8'h5A; cmd_carry = ~cin; cmd_pc = ~pc;
    cyc = 2; rdy_ok = 1'b1;
    while (done !== 1'b1 && cyc < 20) begin
      if (cmd_ready !== 1'b0) rdy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(cyc == ecyc, "R9", "done cycle", cyc, ecyc);
    chk(rdy_ok, "R2", "ready low while busy", {31'd0, rdy_ok}, 1);
    chk(pc_out === epc, (op < 8'h10) ? "R5" : ((ewr == 1) ? "R8" : "R10"),
        "pc_out", pc_out, epc);
    chk(carry_out === ec, (op < 8'h10) ? "R6" : ((ewr == 1) ? "R8" : "R10"),
        "carry_out", {31'd0, carry_out}, {31'd0, ec});
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", {31'd0, done}, 0);
    chk(rd_cnt == 1 && !addr_bad, "R3", "single read in page 0", rd_cnt, 1);
    chk(wr_cnt == ewr, (ewr == 1) ? "R7" : "R6", "write count", wr_cnt, ewr);
    same = 1'b1;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) same = 1'b0;
    chk(same, (ewr == 1) ? "R7" : "R4", "memory image", {24'd0, mem[a]}, {24'd0, shadow[a]});
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd4242);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_ready === 1'b1 && done === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
        "R1", "reset outputs", {28'd0, cmd_ready, done, mem_rd, mem_wr}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_rd === 1'b0 && mem_wr === 1'b0 && done === 1'b0, "R1", "idle quiet",
        {29'd0, mem_rd, mem_wr, done}, 0);

    // R4 directed: bit 7 set, branch-on-one and branch-on-zero
    mem[8'h40] = 8'h80; shadow[8'h40] = 8'h80;
    run(8'h0E, 8'h40, 8'h10, 16'h1000, 1'b0);
    run(8'h0F, 8'h40, 8'h10, 16'h1000, 1'b0);
    // R5 extremes with wrap
    mem[8'h41] = 8'h01; shadow[8'h41] = 8'h01;
    run(8'h00, 8'h41, 8'h80, 16'h0001, 1'b1);
    run(8'h00, 8'h41, 8'h7F, 16'hFFF0, 1'b0);
    run(8'h01, 8'h41, 8'h80, 16'hFFFE, 1'b1);
    // R7 set an already-set bit, top address
    mem[8'hFF] = 8'h08; shadow[8'hFF] = 8'h08;
    run(8'h16, 8'hFF, 8'h00, 16'h2222, 1'b1);
    run(8'h10, 8'hFF, 8'h00, 16'hFFFF, 1'b0);
    // R10 unsupported opcodes
    run(8'h11, 8'h42, 8'h05, 16'h3000, 1'b1);
    run(8'h20, 8'h42, 8'h05, 16'h3000, 1'b0);

    for (int k = 0; k < 400; k++) begin
      logic [7:0] op;
      op = ($urandom % 16 == 0) ? 8'($urandom) : 8'($urandom % 32);
      run(op, 8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule